// File: doc/BRIEF.md
# Bus Access Frame Strobe Generator

This block drives a frame marker for a simple parallel host bus. It watches the read and write strobes of the bus and counts how many accesses have finished. A 4-bit configuration value N divides the accesses into groups of N+1. The frame output is raised only during the first access of each group. With N at zero, every access is framed.

The frame output is formed combinationally from the registered access counter and the live strobes. It therefore rises and falls on the same clock cycles as the strobe that it marks. The counter advances once each access ends. The counter returns to zero on reset and whenever the configuration value changes, so the first access after either event is always framed. Only the strobe-qualified framing mode is implemented. The half-duty framing variant is not present.

Top module: `frame_strobe_gen`

## Requirements
- R1: After a synchronous reset, the access counter is zero. The frame output is low while both strobes are low, and the first access after reset is framed.
- R2: The frame output is never high unless the read strobe or the write strobe is high.
- R3: With the count value at 0, the frame output equals the logical OR of the read and write strobes, so every access is framed.
- R4: With the count value at 1, accesses alternate framed and unframed, starting with a framed one.
- R5: With the count value at N (0 to 15), the frame output is high during exactly one access in every N+1. The framed access is the first one of each group.
- R6: Read accesses and write accesses advance the grouping identically, in any mix.
- R7: A strobe period in which read and write are both high counts as one access.
- R8: A change of the count value restarts the grouping. The next access that starts at least one clock edge after the change is framed.
- R9: The frame output rises in the same cycle as the strobe it marks and falls in the same cycle as that strobe, with no added register delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rdStrobe | input | 1 | Bus read strobe, active high |
| wrStrobe | input | 1 | Bus write strobe, active high |
| frameCount | input | 4 | Group size minus one (N) |
| frameOut | output | 1 | Frame marker |

## Verification
The largest count value (15) is exercised so that a counter which wraps at the wrong value, or which overflows its width, frames the wrong access. A count change made in the middle of a group shows whether the design restarts the grouping; a design that ignored the change would leave the next access unframed. An access with both strobes high, followed by further accesses, shows whether that period was counted twice; double counting would shift every later frame. The frame output is sampled immediately after each strobe edge and before the next clock edge, so a registered output would be caught one cycle late on both edges.

// File: rtl/frame_strobe_pkg.sv
package frame_strobe_pkg;

  // Strobes passed from the control module to the datapath module.
  typedef struct packed {
    logic live;     // the bus strobe is currently asserted (read or write)
    logic advance;  // an access ended at this clock edge
    logic clear;    // the grouping must restart at this clock edge
  } ctrlStrobes_t;

endpackage

// File: rtl/frame_strobe_ctrl.sv
module frame_strobe_ctrl
  import frame_strobe_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rdStrobe,
  input  logic             wrStrobe,
  input  logic [CNT_W-1:0] frameCount,
  output ctrlStrobes_t     ctrl
);

  logic             busActive;
  logic             busActiveQ;
  logic [CNT_W-1:0] cfgQ;

  // Read and write merge into a single access indication. When both are high
  // they still form one access.
  assign busActive = rdStrobe | wrStrobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      busActiveQ <= 1'b0;
      cfgQ       <= frameCount;
    end else begin
      busActiveQ <= busActive;
      cfgQ       <= frameCount;
    end
  end

  always_comb begin
    ctrl.live    = busActive;
    ctrl.advance = busActiveQ & ~busActive;
    ctrl.clear   = (cfgQ != frameCount);
  end

endmodule

// File: rtl/frame_strobe_dp.sv
module frame_strobe_dp
  import frame_strobe_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] frameCount,
  input  ctrlStrobes_t     ctrl,
  output logic             frameOut
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] accessIdx;
  logic [CNT_W-1:0] accessIdxNext;
  logic             atGroupEnd;

  assign atGroupEnd = (accessIdx == frameCount);

  always_comb begin
    accessIdxNext = accessIdx;
    if (ctrl.clear)
      accessIdxNext = CNT_ZERO;
    else if (ctrl.advance)
      accessIdxNext = atGroupEnd ? CNT_ZERO : accessIdx + CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) accessIdx <= CNT_ZERO;
    else     accessIdx <= accessIdxNext;
  end

  // The frame output is combinational, so it follows the live strobe
  // without an added cycle of delay.
  assign frameOut = ctrl.live & (accessIdx == CNT_ZERO);

endmodule

// File: rtl/frame_strobe_gen.sv
module frame_strobe_gen
  import frame_strobe_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rdStrobe,
  input  logic             wrStrobe,
  input  logic [CNT_W-1:0] frameCount,
  output logic             frameOut
);

  ctrlStrobes_t ctrlBus;

  frame_strobe_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk        (clk),
    .rst        (rst),
    .rdStrobe   (rdStrobe),
    .wrStrobe   (wrStrobe),
    .frameCount (frameCount),
    .ctrl       (ctrlBus)
  );

  frame_strobe_dp #(.CNT_W(CNT_W)) uDp (
    .clk        (clk),
    .rst        (rst),
    .frameCount (frameCount),
    .ctrl       (ctrlBus),
    .frameOut   (frameOut)
  );

endmodule

// File: rtl/frame_strobe_checker.sv
module frame_strobe_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             rdStrobe,
  input logic             wrStrobe,
  input logic [CNT_W-1:0] frameCount,
  input logic             frameOut
);

  AST_FRAME_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    frameOut |-> (rdStrobe | wrStrobe)); // R2

  AST_RESET_FRAMES_FIRST: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (frameOut == (rdStrobe | wrStrobe))); // R1

  AST_ZERO_COUNT_IS_OR: assert property (@(posedge clk) disable iff (rst)
    ((frameCount == '0) && (frameCount == $past(frameCount)))
      |-> (frameOut == (rdStrobe | wrStrobe))); // R3

  AST_CHANGE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (frameCount != $past(frameCount)) |=> (frameOut == (rdStrobe | wrStrobe))); // R8

endmodule

bind frame_strobe_gen frame_strobe_checker #(.CNT_W(CNT_W)) uChecker (
  .clk        (clk),
  .rst        (rst),
  .rdStrobe   (rdStrobe),
  .wrStrobe   (wrStrobe),
  .frameCount (frameCount),
  .frameOut   (frameOut)
);

// File: tb/frame_strobe_gen_test.sv
`timescale 1ns/1ps
module frame_strobe_gen_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rdStrobe = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [3:0] frameCount = 4'd0;
  logic       frameOut;

  int vecCount  = 0;
  int failCount = 0;

  always #5 clk = ~clk;

  frame_strobe_gen uut (
    .clk        (clk),
    .rst        (rst),
    .rdStrobe   (rdStrobe),
    .wrStrobe   (wrStrobe),
    .frameCount (frameCount),
    .frameOut   (frameOut)
  );

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // One access: raise the strobes at a falling edge, hold them for holdCycles
  // rising edges, then drop them. Leave one rising edge idle afterwards.
  task automatic doAccess(input logic r, input logic w, input int holdCycles,
                          input logic expFrame, input string tag);
    @(negedge clk);
    rdStrobe = r; wrStrobe = w;
    #1 check(frameOut, expFrame, tag, "frame at strobe rise (R9)");
    repeat (holdCycles) @(posedge clk);
    @(negedge clk);
    #1 check(frameOut, expFrame, tag, "frame held during access");
    rdStrobe = 1'b0; wrStrobe = 1'b0;
    #1 check(frameOut, 1'b0, tag, "frame drops with strobe (R2/R9)");
  endtask

  task automatic setCfg(input logic [3:0] v);
    @(negedge clk);
    frameCount = v;
    @(negedge clk);
  endtask

  task automatic runGroups(input logic [3:0] n, input int accesses, input string tag);
    for (int i = 0; i < accesses; i++) begin
      logic useRd;
      useRd = (i % 2 == 0);
      doAccess(useRd, ~useRd, 1 + (i % 3), (i % (int'(n) + 1)) == 0, tag);
    end
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1 check(frameOut, 1'b0, "R1", "idle after reset");
    frameCount = 4'd3;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    doAccess(1'b0, 1'b1, 1, 1'b1, "R1");
    doAccess(1'b1, 1'b0, 1, 1'b0, "R1");
  endtask

  task automatic testCountZero();
    setCfg(4'd0);
    for (int i = 0; i < 5; i++)
      doAccess(i[0], ~i[0], 1 + i, 1'b1, "R3");
  endtask

  task automatic testCountOne();
    setCfg(4'd1);
    runGroups(4'd1, 6, "R4");
  endtask

  task automatic testCountN();
    setCfg(4'd2);
    runGroups(4'd2, 7, "R5");
    setCfg(4'd15);
    runGroups(4'd15, 18, "R5");
  endtask

  task automatic testMixed();
    setCfg(4'd2);
    doAccess(1'b0, 1'b1, 1, 1'b1, "R6");
    doAccess(1'b0, 1'b1, 2, 1'b0, "R6");
    doAccess(1'b1, 1'b0, 1, 1'b0, "R6");
    doAccess(1'b1, 1'b0, 1, 1'b1, "R6");
    doAccess(1'b1, 1'b0, 3, 1'b0, "R6");
    doAccess(1'b0, 1'b1, 1, 1'b0, "R6");
    doAccess(1'b0, 1'b1, 1, 1'b1, "R6");
  endtask

  task automatic testBothHigh();
    setCfg(4'd1);
    doAccess(1'b1, 1'b1, 2, 1'b1, "R7");
    doAccess(1'b1, 1'b0, 1, 1'b0, "R7");
    doAccess(1'b1, 1'b1, 1, 1'b1, "R7");
    doAccess(1'b0, 1'b1, 1, 1'b0, "R7");
  endtask

  task automatic testCfgChange();
    setCfg(4'd3);
    doAccess(1'b1, 1'b0, 1, 1'b1, "R8");
    doAccess(1'b0, 1'b1, 1, 1'b0, "R8");
    setCfg(4'd2);
    doAccess(1'b1, 1'b0, 1, 1'b1, "R8");
    doAccess(1'b1, 1'b0, 1, 1'b0, "R8");
    setCfg(4'd3);
    doAccess(1'b0, 1'b1, 1, 1'b1, "R8");
  endtask

  initial begin
    #2000000;
    failCount++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    testReset();
    testCountZero();
    testCountOne();
    testCountN();
    testMixed();
    testBothHigh();
    testCfgChange();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule